// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

A combinational eight-bit arithmetic and logic unit for a small microcontroller core. Each cycle it takes two operands, an operation code, the incoming carry and the current zero flag. From these it produces an eight-bit result and six status flags: carry C, zero Z, negative N, two's-complement overflow V, sign S and half-carry H. Each operation class updates the flags by its own rule. A six-bit status register captures the computed flags on any cycle where its write enable is high.

The unary operations (one's complement, negate, increment, decrement, shifts and rotates) work on `opnd_a` and ignore `opnd_b`. Compare operations drive the difference on `res_o` like a subtraction, and the surrounding core simply does not write it back. Some operations leave H untouched; for these, `flags_o` carries the H bit held in the status register. Operations that leave C untouched pass `carry_in` through. All pins are plain control and data levels: the result is valid in the same cycle as its inputs, and there is no handshake or back-pressure.

Top module: `alu8_flags`

## Requirements
- R1: The flag vector packs C in bit 0, Z in bit 1, N in bit 2, V in bit 3, S in bit 4 and H in bit 5. N is result bit 7, S is N xor V, and Z is set exactly when the result is zero (except as in R9).
- R2: Op code 0 (add) and op code 1 (add with carry_in) give a+b(+carry_in) mod 256. C is the carry out of bit 7 and H the carry out of bit 3. V is set when a and b share a sign that the result does not.
- R3: Op codes 2 (subtract), 3 (subtract with borrow), 4 (compare) and 5 (compare with borrow) give a-b (minus carry_in for codes 3 and 5) mod 256. C is set when b plus the borrow exceeds a unsigned, and H when the low nibble of b plus the borrow exceeds the low nibble of a. V is set when a and b differ in sign and the result's sign differs from a's.
- R4: Op codes 6 (and), 7 (or) and 8 (xor) give the bitwise result, clear V, pass carry_in to C and report the held H.
- R5: Op code 9 (one's complement) gives 0xFF-a, always sets C, clears V and reports the held H.
- R6: Op code 10 (negate) gives 0-a mod 256. C is set when the result is nonzero, V only when the result is 0x80, and H when a's low nibble is nonzero.
- R7: Op code 11 (increment) and op code 12 (decrement) give a+1 and a-1 mod 256. Increment sets V only for a result of 0x80 and decrement only for 0x7F. Both pass carry_in to C and report the held H.
- R8: Op codes 13 (shift left, 0 in), 14 (shift right, 0 in), 15 (arithmetic shift right, bit 7 kept), 16 (rotate left through carry_in) and 17 (rotate right through carry_in) put the bit shifted out into C and set V to N xor C. Each reports the held H.
- R9: For op codes 3 and 5, Z is cleared when the result is nonzero. When the result is zero, Z equals zero_in.
- R10: The status register is zero after reset, loads flags_o on a clock edge with stat_we high, and holds otherwise. The held H is its bit 5.
- R11: Op codes 18 to 31 pass a to the result, clear V, pass carry_in to C, report the held H, and set N, Z and S per R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | First operand; sole operand of unary operations |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry flag |
| zero_in | input | 1 | Incoming zero flag, used by the chained operations |
| stat_we | input | 1 | Status register write enable |
| res_o | output | 8 | Operation result |
| flags_o | output | 6 | Flags computed this cycle |
| stat_q | output | 6 | Status register contents |

## Verification
The status register load and the held-H pass-through can fall in the same cycle. When an operation that keeps H runs with stat_we high, the register's own H feeds back through flags_o into its input. The bench provokes this by loading H=1 with an add and then running an and with the enable still high. It then checks that the stored H stays 1 while Z and C take their new values. Sticky Z chaining with zero_in is swept in both polarities across every operand pair of the borrow-chained codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ASR = 5'd15,
    OP_ROL = 5'd16, OP_ROR = 5'd17
  } alu_op_e;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_W = 6;
endpackage

// File: rtl/alu8_adder.sv
// Split-nibble adder: exposes the carry out of bit 3 and signed overflow.
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         co,
  output logic         hco,
  output logic         ovf
);
  localparam int HW = W - 4;

  logic [4:0]  lo;
  logic [HW:0] hi;

  always_comb begin
    lo  = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'b0, ci};
    hi  = {1'b0, x[W-1:4]} + {1'b0, y[W-1:4]} + {{HW{1'b0}}, lo[4]};
    sum = {hi[HW-1:0], lo[3:0]};
    co  = hi[HW];
    hco = lo[4];
    ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu8_bitops.sv
// Bitwise operations, one's complement, shifts and rotates.
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         sh_out
);
  always_comb begin
    r      = a;
    sh_out = 1'b0;
    unique case (op)
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_COM: r = ~a;
      OP_LSL: begin r = {a[W-2:0], 1'b0};    sh_out = a[W-1]; end
      OP_ROL: begin r = {a[W-2:0], cin};     sh_out = a[W-1]; end
      OP_LSR: begin r = {1'b0, a[W-1:1]};    sh_out = a[0];   end
      OP_ROR: begin r = {cin, a[W-1:1]};     sh_out = a[0];   end
      OP_ASR: begin r = {a[W-1], a[W-1:1]};  sh_out = a[0];   end
      default: begin r = a; sh_out = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  input  logic              zero_in,
  input  logic              stat_we,
  output logic [DATA_W-1:0] res_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic [FLG_W-1:0]  stat_q
);
  localparam int MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] add_x, add_y, add_sum, bit_r, res;
  logic              add_ci, add_co, add_hco, add_ovf, bit_sh;
  logic              fc, fz, fn, fv, fh;
  logic [FLG_W-1:0]  flags_d, stat_r;

  assign op = alu_op_e'(op_sel);

  // One shared adder serves add, subtract, compare, negate, inc and dec.
  always_comb begin
    add_x  = opnd_a;
    add_y  = opnd_b;
    add_ci = 1'b0;
    unique case (op)
      OP_ADC:         add_ci = carry_in;
      OP_SUB, OP_CMP: begin add_y = ~opnd_b; add_ci = 1'b1; end
      OP_SBC, OP_CPC: begin add_y = ~opnd_b; add_ci = ~carry_in; end
      OP_NEG:         begin add_x = '0; add_y = ~opnd_a; add_ci = 1'b1; end
      OP_INC:         begin add_y = '0; add_ci = 1'b1; end
      OP_DEC:         begin add_y = '1; add_ci = 1'b0; end
      default:        add_ci = 1'b0;
    endcase
  end

  alu8_adder #(.W(DATA_W)) u_add (
    .x(add_x), .y(add_y), .ci(add_ci),
    .sum(add_sum), .co(add_co), .hco(add_hco), .ovf(add_ovf)
  );

  alu8_bitops #(.W(DATA_W)) u_bit (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(carry_in),
    .r(bit_r), .sh_out(bit_sh)
  );

  always_comb begin
    res = opnd_a;
    fc  = carry_in;
    fv  = 1'b0;
    fh  = stat_r[FLG_H];
    unique case (op)
      OP_ADD, OP_ADC: begin
        res = add_sum; fc = add_co; fh = add_hco; fv = add_ovf;
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG: begin
        res = add_sum; fc = ~add_co; fh = ~add_hco; fv = add_ovf;
      end
      OP_INC, OP_DEC: begin
        res = add_sum; fv = add_ovf;
      end
      OP_AND, OP_OR, OP_XOR: res = bit_r;
      OP_COM: begin res = bit_r; fc = 1'b1; end
      OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
        res = bit_r; fc = bit_sh; fv = bit_r[MSB] ^ bit_sh;
      end
      default: res = opnd_a;
    endcase
    fn = res[MSB];
    if (op == OP_SBC || op == OP_CPC) fz = (res == '0) && zero_in;
    else                              fz = (res == '0);
  end

  always_comb begin
    flags_d        = '0;
    flags_d[FLG_C] = fc;
    flags_d[FLG_Z] = fz;
    flags_d[FLG_N] = fn;
    flags_d[FLG_V] = fv;
    flags_d[FLG_S] = fn ^ fv;
    flags_d[FLG_H] = fh;
  end

  alu8_status_reg #(.N(FLG_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .we(stat_we), .d(flags_d), .q(stat_r)
  );

  assign res_o   = res;
  assign flags_o = flags_d;
  assign stat_q  = stat_r;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        op_sel,
  input logic [DATA_W-1:0] opnd_a,
  input logic              carry_in,
  input logic              zero_in,
  input logic              stat_we,
  input logic [DATA_W-1:0] res_o,
  input logic [FLG_W-1:0]  flags_o,
  input logic [FLG_W-1:0]  stat_q
);
  logic is_shift, is_chain, is_logic, is_incdec;
  assign is_shift  = (op_sel >= 5'(OP_LSL)) && (op_sel <= 5'(OP_ROR));
  assign is_chain  = (op_sel == 5'(OP_SBC)) || (op_sel == 5'(OP_CPC));
  assign is_logic  = (op_sel >= 5'(OP_AND)) && (op_sel <= 5'(OP_XOR));
  assign is_incdec = (op_sel == 5'(OP_INC)) || (op_sel == 5'(OP_DEC));

  AST_COM_FORCES_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 5'(OP_COM)) |-> (flags_o[FLG_C] && !flags_o[FLG_V] && res_o == ~opnd_a)); // R5
  AST_SHIFT_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    is_shift |-> (flags_o[FLG_V] == (flags_o[FLG_N] ^ flags_o[FLG_C]))); // R8
  AST_CHAIN_Z_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_chain && res_o != '0) |-> !flags_o[FLG_Z]); // R9
  AST_CHAIN_Z_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_chain && res_o == '0) |-> (flags_o[FLG_Z] == zero_in)); // R9
  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |-> (!flags_o[FLG_V] && flags_o[FLG_C] == carry_in)); // R4
  AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    is_incdec |-> (flags_o[FLG_C] == carry_in)); // R7
  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> (stat_q == $past(flags_o))); // R10
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> $stable(stat_q)); // R10
endmodule

bind alu8_flags alu8_flags_chk #(.DATA_W(DATA_W)) u_alu8_flags_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
  .carry_in(carry_in), .zero_in(zero_in), .stat_we(stat_we),
  .res_o(res_o), .flags_o(flags_o), .stat_q(stat_q)
);

// File: tb/test_alu8_flags.sv
`timescale 1ns/100ps
module test_alu8_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic       carry_in = 1'b0, zero_in = 1'b0, stat_we = 1'b0;
  logic [7:0] res_o;
  logic [5:0] flags_o, stat_q;

  int n_chk = 0, n_bad = 0, held_h = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu8_flags i_alu8_flags (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_in(carry_in), .zero_in(zero_in), .stat_we(stat_we),
    .res_o(res_o), .flags_o(flags_o), .stat_q(stat_q)
  );

  function automatic string tag_of(input int op);
    if (op <= 1)  return "R2 R1";
    if (op <= 5)  return (op == 3 || op == 5) ? "R3 R9" : "R3 R1";
    if (op <= 8)  return "R4";
    if (op == 9)  return "R5";
    if (op == 10) return "R6";
    if (op <= 12) return "R7";
    if (op <= 17) return "R8";
    return "R11";
  endfunction

  function automatic int in_range(input int st);
    return (st > 127 || st < -128) ? 1 : 0;
  endfunction

  // Reference built from the requirement text with plain integer arithmetic.
  function automatic void ref_alu(input int op, a, b, ci, zi, hh,
                                  output int r, output int f);
    int sa, sb, t, cc, c, h, v, n, z, s;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    c = ci; h = hh; v = 0; r = a;
    case (op)
      0, 1: begin
        cc = (op == 1) ? ci : 0;
        t = a + b + cc; r = t & 255;
        c = (t > 255) ? 1 : 0;
        h = (((a & 15) + (b & 15) + cc) > 15) ? 1 : 0;
        v = in_range(sa + sb + cc);
      end
      2, 3, 4, 5: begin
        cc = (op == 3 || op == 5) ? ci : 0;
        t = a - b - cc; r = t & 255;
        c = ((b + cc) > a) ? 1 : 0;
        h = ((a & 15) < ((b & 15) + cc)) ? 1 : 0;
        v = in_range(sa - sb - cc);
      end
      6: r = a & b;
      7: r = a | b;
      8: r = a ^ b;
      9: begin r = 255 - a; c = 1; end
      10: begin
        r = (256 - a) & 255; c = (a != 0) ? 1 : 0;
        h = ((a & 15) != 0) ? 1 : 0; v = (a == 128) ? 1 : 0;
      end
      11: begin r = (a + 1) & 255; v = (a == 127) ? 1 : 0; end
      12: begin r = (a + 255) & 255; v = (a == 128) ? 1 : 0; end
      13: begin r = (a * 2) & 255; c = a / 128; end
      14: begin r = a / 2; c = a & 1; end
      15: begin r = (a / 2) | (a & 128); c = a & 1; end
      16: begin r = ((a * 2) & 255) | ci; c = a / 128; end
      17: begin r = (a / 2) | (ci * 128); c = a & 1; end
      default: r = a;
    endcase
    n = r / 128;
    if (op >= 13 && op <= 17) v = n ^ c;
    if (op == 3 || op == 5) z = (r == 0 && zi == 1) ? 1 : 0;
    else                    z = (r == 0) ? 1 : 0;
    s = n ^ v;
    f = h * 32 + s * 16 + v * 8 + n * 4 + z * 2 + c;
  endfunction

  task automatic run_vec(input int op, a, b, ci, zi);
    int er, ef;
    op_sel = 5'(op); opnd_a = 8'(a); opnd_b = 8'(b);
    carry_in = 1'(ci); zero_in = 1'(zi);
    #1;
    ref_alu(op, a, b, ci, zi, held_h, er, ef);
    n_chk++;
    if (res_o !== 8'(er) || flags_o !== 6'(ef)) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h ci=%0d zi=%0d: got r=%02h f=%06b, want r=%02h f=%06b",
               tag_of(op), op, a, b, ci, zi, res_o, flags_o, 8'(er), 6'(ef));
    end
  endtask

  task automatic check_stat(input logic [5:0] want, input string what);
    n_chk++;
    if (stat_q !== want) begin
      n_bad++;
      $display("FAIL R10 %s: got stat=%06b, want stat=%06b", what, stat_q, want);
    end
  endtask

  task automatic sweep_unary();
    for (int op = 9; op <= 17; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 4; k++)
          run_vec(op, a, (a * 37 + k * 91) & 255, k & 1, k / 2);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_stat(6'b000000, "after reset");
    rst_n = 1'b1;

    // Load H=1 via 0x0F+0x01: flags H only.
    @(negedge clk);
    stat_we = 1'b1;
    run_vec(0, 8'h0F, 8'h01, 0, 0);
    @(posedge clk); @(negedge clk);
    check_stat(6'b100000, "load on enable");
    held_h = 1;
    stat_we = 1'b0;

    // Enable low: 0xFF+0x01 sets C,Z,H but the register must hold.
    run_vec(0, 8'hFF, 8'h01, 0, 0);
    @(posedge clk); @(negedge clk);
    check_stat(6'b100000, "hold with enable low");

    // Same cycle: and keeps H from the register while the register loads.
    stat_we = 1'b1;
    run_vec(6, 8'h00, 8'h00, 0, 0);
    @(posedge clk); @(negedge clk);
    check_stat(6'b100010, "held H written back during load");
    stat_we = 1'b0;

    // Exhaustive binary ops with held H = 1.
    for (int op = 0; op <= 8; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          run_vec(op, a, b, (a ^ (b >> 1)) & 1, ((a >> 2) ^ b) & 1);
    sweep_unary();

    // Clear H (0+0 gives Z only) and rerun unary ops with held H = 0.
    @(negedge clk);
    stat_we = 1'b1;
    run_vec(0, 0, 0, 0, 0);
    @(posedge clk); @(negedge clk);
    check_stat(6'b000010, "reload with H cleared");
    held_h = 0;
    stat_we = 1'b0;
    sweep_unary();

    // Unused codes behave as pass-through of a.
    for (int op = 18; op < 32; op++)
      for (int a = 0; a < 256; a++)
        run_vec(op, a, 255 - a, a & 1, (a >> 1) & 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule